// File: doc/BRIEF.md
# Receive Frame Status Read Sequencer

This block sits between a small receive queue and the host read port. Each queue entry holds one 16-bit data word and an end-of-frame tag. The host reads data words from the queue, and the block marks the read that returns the tagged last word. After that read, the block holds back all further data until the host has consumed four bytes of receive frame status.

The status value comes from an input. The block captures it in the same cycle that the end-of-frame word is read. The host can drain the four status bytes through two access paths, and it may mix them freely:

- **Queue-direct path:** reads simply continue after the end of frame, so the status bytes appear as if appended to the packet.
- **Register path:** reads target a fixed status address.

Both paths advance one shared byte counter. Every read returns its response one cycle after the request.

Top module: `rx_frame_status_seq`

## Requirements
- R1: After reset, rdValid and rdEof are low and wrReady is high.
- R2: With no status pending, a read on the queue-direct path (rdDirect=1) or a register read at address 5'b00000 (rdDirect=0) pops the oldest word. The word is returned on rdData with rdValid high in the cycle after the request.
- R3: rdEof is high exactly on the response that returns a word pushed with wrLast=1.
- R4: rdEof is low on every status byte response and on every other response.
- R5: Once a tagged word has been read, queue-direct reads return the four status bytes least-significant first. Each byte is copied into both bytes of rdData, for example 8'hAA gives 16'hAAAA.
- R6: While status is pending, register reads at address 5'b00110 return the next status byte, in the same order and format as R5.
- R7: While status bytes remain unread, register reads at address 5'b00000 return rdValid low and pop nothing.
- R8: The two paths share one byte counter, so they may alternate. Data delivery resumes only after four status bytes in total have been read.
- R9: A data read while the queue is empty and no status is pending returns rdValid low and changes no state.
- R10: The status bytes come from the frameStatus value sampled on the clock edge that reads the end-of-frame word. Later changes to frameStatus do not affect them.
- R11: A register read at any address other than 5'b00000 or 5'b00110, or at 5'b00110 with no status pending, returns rdValid low.
- R12: wrReady is low while the queue holds DEPTH words. A push attempted then is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Push a word into the receive queue |
| wrData | input | 16 | Word to push |
| wrLast | input | 1 | Pushed word is the last of its frame |
| wrReady | output | 1 | Queue has room |
| frameStatus | input | 32 | Receive frame status of the frame being read |
| rdReq | input | 1 | Host read request, one cycle per read |
| rdDirect | input | 1 | 1: queue-direct path, 0: register path |
| rdAddr | input | 5 | Register address, ignored on the queue-direct path |
| rdValid | output | 1 | Response carries data |
| rdData | output | 16 | Response word or duplicated status byte |
| rdEof | output | 1 | Response is the last word of a frame |

## Verification
The assertions check several rules on every cycle:
- rdEof never appears without rdValid, and never on a status response.
- Status responses carry identical byte lanes.
- The byte counter is zero whenever no status is pending.
- A register queue read while status is pending never pops.
- A full queue never changes its occupancy on a dropped push.

Only the bench scenarios can show the rest: the order of data and status bytes, status capture at the end-of-frame edge, the mixing of the two paths, and the point at which data delivery resumes.

// File: rtl/rxseq_pkg.sv
package rxseq_pkg;
  localparam int STATUS_BYTES = 4;

  typedef struct packed {
    logic       pop;
    logic       sendStatus;
    logic [1:0] statIdx;
    logic       respValid;
    logic       latchStatus;
  } seqStrobe_t;
endpackage

// File: rtl/rxseq_ctrl.sv
module rxseq_ctrl
  import rxseq_pkg::*;
#(
  parameter int AW        = 5,
  parameter int FIFO_ADDR = 0,
  parameter int STAT_ADDR = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rdReq,
  input  logic          rdDirect,
  input  logic [AW-1:0] rdAddr,
  input  logic          fifoEmpty,
  input  logic          headLast,
  output seqStrobe_t    strobe
);
  logic       statusPend;
  logic [1:0] statCnt;
  logic       regFifoRd;
  logic       regStatRd;
  logic       dataRd;

  always_comb begin
    regFifoRd = rdReq && !rdDirect && (rdAddr == AW'(FIFO_ADDR));
    regStatRd = rdReq && !rdDirect && (rdAddr == AW'(STAT_ADDR));
    dataRd    = (rdReq && rdDirect) || regFifoRd;
    strobe    = '0;
    if (statusPend) begin
      if ((rdReq && rdDirect) || regStatRd) begin
        strobe.sendStatus = 1'b1;
        strobe.respValid  = 1'b1;
        strobe.statIdx    = statCnt;
      end
    end else if (dataRd && !fifoEmpty) begin
      strobe.pop         = 1'b1;
      strobe.respValid   = 1'b1;
      strobe.latchStatus = headLast;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusPend <= 1'b0;
      statCnt    <= '0;
    end else if (strobe.latchStatus) begin
      statusPend <= 1'b1;
      statCnt    <= '0;
    end else if (strobe.sendStatus) begin
      statCnt <= statCnt + 2'd1;
      if (statCnt == 2'(STATUS_BYTES - 1)) statusPend <= 1'b0;
    end
  end

  // R7
  reg_fifo_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusPend && regFifoRd |-> !strobe.pop && !strobe.respValid);

  // R8
  cnt_idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !statusPend |-> statCnt == 2'd0);

  // R8
  status_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sendStatus && statCnt == 2'd3 |=> !statusPend);

  // R9
  no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> !fifoEmpty);
endmodule

// File: rtl/rxseq_data.sv
module rxseq_data
  import rxseq_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrValid,
  input  logic [DW-1:0] wrData,
  input  logic          wrLast,
  output logic          wrReady,
  input  logic [31:0]   frameStatus,
  input  seqStrobe_t    strobe,
  output logic          fifoEmpty,
  output logic          headLast,
  output logic          rdValid,
  output logic [DW-1:0] rdData,
  output logic          rdEof
);
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int LANES = DW / 8;

  logic [DW:0]    mem [DEPTH];
  logic [PW-1:0]  wrPtr, rdPtr;
  logic [CW-1:0]  count;
  logic [31:0]    statusReg;
  logic           push;
  logic [7:0]     statByte;
  logic [DW-1:0]  statWord;

  assign wrReady   = (count != CW'(DEPTH));
  assign fifoEmpty = (count == '0);
  assign push      = wrValid && wrReady;
  assign headLast  = mem[rdPtr][DW];
  assign statByte  = statusReg[8*strobe.statIdx +: 8];

  generate
    for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
      assign statWord[8*lane +: 8] = statByte;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= {wrLast, wrData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push)
        wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (strobe.pop)
        rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CW'(push) - CW'(strobe.pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusReg <= '0;
    else if (strobe.latchStatus) statusReg <= frameStatus;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
      rdEof   <= 1'b0;
    end else begin
      rdValid <= strobe.respValid;
      rdEof   <= strobe.pop && headLast;
      if (strobe.sendStatus) rdData <= statWord;
      else if (strobe.pop)   rdData <= mem[rdPtr][DW-1:0];
    end
  end

  // R3
  eof_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEof |-> rdValid);

  // R4
  status_no_eof_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sendStatus |=> !rdEof);

  // R5
  status_dup_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sendStatus |=> rdData[DW-1 -: 8] == rdData[7:0]);

  // R12
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrReady && !strobe.pop |=> $stable(count));
endmodule

// File: rtl/rx_frame_status_seq.sv
module rx_frame_status_seq
  import rxseq_pkg::*;
#(
  parameter int DW        = 16,
  parameter int DEPTH     = 8,
  parameter int AW        = 5,
  parameter int FIFO_ADDR = 0,
  parameter int STAT_ADDR = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrValid,
  input  logic [DW-1:0] wrData,
  input  logic          wrLast,
  output logic          wrReady,
  input  logic [31:0]   frameStatus,
  input  logic          rdReq,
  input  logic          rdDirect,
  input  logic [AW-1:0] rdAddr,
  output logic          rdValid,
  output logic [DW-1:0] rdData,
  output logic          rdEof
);
  seqStrobe_t strobe;
  logic       fifoEmpty;
  logic       headLast;

  rxseq_ctrl #(.AW(AW), .FIFO_ADDR(FIFO_ADDR), .STAT_ADDR(STAT_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .rdDirect(rdDirect),
    .rdAddr(rdAddr), .fifoEmpty(fifoEmpty), .headLast(headLast),
    .strobe(strobe)
  );

  rxseq_data #(.DW(DW), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .wrLast(wrLast), .wrReady(wrReady), .frameStatus(frameStatus),
    .strobe(strobe), .fifoEmpty(fifoEmpty), .headLast(headLast),
    .rdValid(rdValid), .rdData(rdData), .rdEof(rdEof)
  );
endmodule

// File: tb/rx_frame_status_seq_bench.sv
module rx_frame_status_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [15:0] wrData = '0;
  logic        wrLast = 1'b0;
  logic        wrReady;
  logic [31:0] frameStatus = '0;
  logic        rdReq = 1'b0;
  logic        rdDirect = 1'b0;
  logic [4:0]  rdAddr = '0;
  logic        rdValid;
  logic [15:0] rdData;
  logic        rdEof;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic reqDly = 1'b0;

  typedef struct {
    logic        valid;
    logic [15:0] data;
    logic        eof;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  rx_frame_status_seq u_rx_frame_status_seq (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .wrLast(wrLast), .wrReady(wrReady), .frameStatus(frameStatus),
    .rdReq(rdReq), .rdDirect(rdDirect), .rdAddr(rdAddr),
    .rdValid(rdValid), .rdData(rdData), .rdEof(rdEof)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) reqDly <= rdReq;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // monitor: compare each response against the scoreboard
  always @(negedge clk) begin
    if (rstN && reqDly) begin
      expItem_t e;
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard: unexpected response");
      end else begin
        e = expQ.pop_front();
        check({e.tag, " valid/eof"}, {30'd0, rdValid, rdEof}, {30'd0, e.valid, e.eof});
        if (e.valid) check({e.tag, " data"}, {16'd0, rdData}, {16'd0, e.data});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finishRun();
    end
  end

  task automatic pushWord(input logic [15:0] d, input logic last);
    wrValid = 1'b1; wrData = d; wrLast = last;
    @(negedge clk);
    wrValid = 1'b0; wrLast = 1'b0;
  endtask

  task automatic readOp(input logic direct, input logic [4:0] addr,
                        input logic expValid, input logic [15:0] expData,
                        input logic expEof, input string tag);
    expItem_t e;
    e.valid = expValid; e.data = expData; e.eof = expEof; e.tag = tag;
    expQ.push_back(e);
    rdReq = 1'b1; rdDirect = direct; rdAddr = addr;
    @(negedge clk);
    rdReq = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rdValid", {31'd0, rdValid}, 32'd0);
    check("R1 rdEof", {31'd0, rdEof}, 32'd0);
    check("R1 wrReady", {31'd0, wrReady}, 32'd1);
    rstN = 1'b1;
    @(negedge clk);

    // R9 empty reads, R11 stray addresses
    readOp(1'b1, 5'd0, 1'b0, 16'h0, 1'b0, "R9 empty direct");
    readOp(1'b0, 5'd0, 1'b0, 16'h0, 1'b0, "R9 empty reg");
    readOp(1'b0, 5'd6, 1'b0, 16'h0, 1'b0, "R11 status idle");
    readOp(1'b0, 5'd5, 1'b0, 16'h0, 1'b0, "R11 other addr");

    // frame A through the direct path
    pushWord(16'h1111, 1'b0);
    pushWord(16'h2222, 1'b1);
    frameStatus = 32'hDDCCBBAA;
    readOp(1'b1, 5'd0, 1'b1, 16'h1111, 1'b0, "R2 direct word");
    readOp(1'b1, 5'd0, 1'b1, 16'h2222, 1'b1, "R3 eof word");
    frameStatus = 32'h0;  // R10 later changes must not matter
    readOp(1'b1, 5'd0, 1'b1, 16'hAAAA, 1'b0, "R5 R10 status b0");
    readOp(1'b1, 5'd9, 1'b1, 16'hBBBB, 1'b0, "R5 status b1");
    readOp(1'b1, 5'd0, 1'b1, 16'hCCCC, 1'b0, "R5 status b2");
    readOp(1'b1, 5'd0, 1'b1, 16'hDDDD, 1'b0, "R5 status b3");
    readOp(1'b1, 5'd0, 1'b0, 16'h0, 1'b0, "R9 empty after status");

    // frames B and C, register path, mixed status paths
    pushWord(16'h3333, 1'b1);
    pushWord(16'h4444, 1'b0);
    pushWord(16'h5555, 1'b1);
    frameStatus = 32'h44332211;
    readOp(1'b0, 5'd0, 1'b1, 16'h3333, 1'b1, "R2 R3 reg word");
    frameStatus = 32'hFFFFFFFF;
    readOp(1'b0, 5'd0, 1'b0, 16'h0, 1'b0, "R7 reg blocked");
    readOp(1'b0, 5'd6, 1'b1, 16'h1111, 1'b0, "R6 reg status b0");
    readOp(1'b1, 5'd0, 1'b1, 16'h2222, 1'b0, "R8 direct b1");
    readOp(1'b0, 5'd0, 1'b0, 16'h0, 1'b0, "R7 reg blocked again");
    readOp(1'b0, 5'd6, 1'b1, 16'h3333, 1'b0, "R8 reg b2");
    readOp(1'b1, 5'd0, 1'b1, 16'h4444, 1'b0, "R8 direct b3");
    readOp(1'b0, 5'd0, 1'b1, 16'h4444, 1'b0, "R8 data resumes");
    frameStatus = 32'h88776655;
    readOp(1'b1, 5'd0, 1'b1, 16'h5555, 1'b1, "R3 frame C eof");
    readOp(1'b0, 5'd6, 1'b1, 16'h5555, 1'b0, "R4 R6 reg b0");
    readOp(1'b0, 5'd6, 1'b1, 16'h6666, 1'b0, "R4 R6 reg b1");
    readOp(1'b0, 5'd6, 1'b1, 16'h7777, 1'b0, "R4 R6 reg b2");
    readOp(1'b0, 5'd6, 1'b1, 16'h8888, 1'b0, "R4 R6 reg b3");
    readOp(1'b0, 5'd6, 1'b0, 16'h0, 1'b0, "R11 status drained");

    // R12 full queue
    for (int i = 0; i <= DEPTH; i++) pushWord(16'h0100 + 16'(i), 1'b0);
    check("R12 wrReady full", {31'd0, wrReady}, 32'd0);
    for (int i = 0; i < DEPTH; i++)
      readOp(1'b1, 5'd0, 1'b1, 16'h0100 + 16'(i), 1'b0, "R12 R2 drain");
    readOp(1'b1, 5'd0, 1'b0, 16'h0, 1'b0, "R12 dropped push");
    check("R12 wrReady empty", {31'd0, wrReady}, 32'd1);

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: got %0d left expected 0", expQ.size());
    end
    finishRun();
  end
endmodule